// File: doc/BRIEF.md
# Edge-Counting Event Counter with Deferred Match

This block counts transitions on an asynchronous event pin. A polarity control selects the transition that advances the 8-bit count: the rising edge when the control is low, the falling edge when it is high. The count is compared with a programmable match value, but only on the next transition in the opposite direction, once the pulse has ended. When the compare finds equality, the count returns to zero and a single-cycle interrupt pulse is raised on the same clock. If the pin stays at the level it took on the counting edge, the compare and the interrupt wait until it goes back.

A small state machine keeps the two edges paired. In state `ST_ARMED` it waits for a counting edge. The transition `ARMED->HELD` increments the count. In state `ST_HELD` it waits for the compare edge. The transition `HELD->ARMED` makes the compare and may clear the count. No other transitions exist, so an edge that comes in the wrong state is ignored. When the auto-capture enable is high, a capture register follows the live count so that it can be read.

Top module: `evt_counter_top`

## Requirements
- R1: With `inv_i`=0, each rising edge of `evt_i` adds one to the count (transition `ARMED->HELD`).
- R2: With `inv_i`=1, each falling edge of `evt_i` adds one to the count.
- R3: The compare with `match_i` happens only on the edge opposite to the counting edge (transition `HELD->ARMED`). While the pin holds its post-count level, the count stays at its incremented value and no interrupt is raised.
- R4: When the compare finds the count equal to `match_i`, the count becomes 0. On that same clock `irq_o` goes high, so `irq_o` is never high while the count is non-zero.
- R5: `irq_o` is high for exactly one clock cycle per match.
- R6: While `cap_en_i` is 1, `cap_o` takes on each clock the count of the previous cycle. While `cap_en_i` is 0, `cap_o` holds its value.
- R7: A pulse that is high for 2 clocks and low for 2 clocks is counted and compared correctly. The pin passes through a 2-flop synchronizer.
- R8: The count wraps from 255 to 0 when no match clears it. With `match_i`=0, the compare that follows the wrapping count edge fires.
- R9: A new `match_i` value written between pulses applies at the next compare edge.
- R10: Synchronous reset clears the count, `cap_o`, `irq_o`, the synchronizer and the state, which becomes `ST_ARMED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 1 | Asynchronous event pin |
| inv_i | input | 1 | 0: count on rising edges; 1: count on falling edges |
| match_i | input | 8 | Match value for the compare |
| cap_en_i | input | 1 | Auto-capture enable |
| cap_o | output | 8 | Capture register |
| irq_o | output | 1 | Single-cycle match interrupt |

## Verification
The clear of the count and the capture load fall on the same clock. On the cycle in which `irq_o` is high, `cap_o` must still show the matched value, because it took the count from before the clear. On the cycles that follow, it must show zero. The bench provokes this with the capture enable held high through every match, including the match that comes after a held post-count level and the match at the wrap with `match_i`=0. On every interrupt pulse, the monitor compares `cap_o` with `match_i`.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } evc_state_e;

    typedef struct packed {
        logic cnt;
        logic cmp;
    } evc_edges_t;

endpackage

// File: rtl/evc_sync_edge.sv
module evc_sync_edge
    import evc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       evt_i,
    input  logic       inv_i,
    output evc_edges_t edges_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], evt_i};
            prev_q <= sync_q[LAST];
        end
    end

    always_comb begin
        rise        = sync_q[LAST] & ~prev_q;
        fall        = ~sync_q[LAST] & prev_q;
        edges_o.cnt = inv_i ? fall : rise;
        edges_o.cmp = inv_i ? rise : fall;
    end

    // R3: the two edge kinds alternate, so no two compare edges come without a level change between them
    p_cmp_not_repeated_r3: assert property (@(posedge clk) disable iff (rst)
        edges_o.cmp |=> !edges_o.cmp);

endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl
    import evc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  evc_edges_t edges_i,
    input  logic       hit_i,
    output logic       inc_o,
    output logic       clr_o
);
    evc_state_e state_q;
    evc_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ARMED;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (edges_i.cnt) state_d = ST_HELD;
            ST_HELD:  if (edges_i.cmp) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        inc_o = 1'b0;
        clr_o = 1'b0;
        unique case (state_q)
            ST_ARMED: inc_o = edges_i.cnt;
            ST_HELD:  clr_o = edges_i.cmp & hit_i;
            default:  ;
        endcase
    end

    // R3: a held post-count level keeps the machine waiting
    p_held_waits_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HELD && !edges_i.cmp) |=> (state_q == ST_HELD));

    // R1: an increment always leads into the waiting state
    p_inc_enters_held_r1: assert property (@(posedge clk) disable iff (rst)
        inc_o |=> (state_q == ST_HELD));

    // R3: increment and clear never coincide
    p_inc_clr_apart_r3: assert property (@(posedge clk) disable iff (rst)
        !(inc_o && clr_o));

endmodule

// File: rtl/evc_count.sv
module evc_count #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic             cap_en_i,
    input  logic [WIDTH-1:0] match_i,
    output logic             hit_o,
    output logic [WIDTH-1:0] cap_o,
    output logic             irq_o
);
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cap_q;
    logic             irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= clr_i;
            if (clr_i)      cnt_q <= '0;
            else if (inc_i) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           cap_q <= '0;
        else if (cap_en_i) cap_q <= cnt_q;
    end

    assign hit_o = (cnt_q == match_i);
    assign cap_o = cap_q;
    assign irq_o = irq_q;

    // R4: interrupt coincides with a cleared count
    p_irq_with_clear_r4: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (cnt_q == '0));

    // R5: single-cycle interrupt
    p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R6: capture follows the previous count while enabled
    p_cap_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cap_en_i)) |-> (cap_q == $past(cnt_q)));

    // R6: capture holds while disabled
    p_cap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cap_en_i)) |-> $stable(cap_q));

    // R8: the count only steps by one (wrapping) or returns to zero
    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt_q == $past(cnt_q) || cnt_q == WIDTH'($past(cnt_q) + 1'b1) || cnt_q == '0));

endmodule

// File: rtl/evt_counter_top.sv
module evt_counter_top
    import evc_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             inv_i,
    input  logic [WIDTH-1:0] match_i,
    input  logic             cap_en_i,
    output logic [WIDTH-1:0] cap_o,
    output logic             irq_o
);
    evc_edges_t edges;
    logic       hit;
    logic       inc;
    logic       clr;

    evc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_i),
        .inv_i   (inv_i),
        .edges_o (edges)
    );

    evc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .edges_i (edges),
        .hit_i   (hit),
        .inc_o   (inc),
        .clr_o   (clr)
    );

    evc_count #(.WIDTH(WIDTH)) u_count (
        .clk      (clk),
        .rst      (rst),
        .inc_i    (inc),
        .clr_i    (clr),
        .cap_en_i (cap_en_i),
        .match_i  (match_i),
        .hit_o    (hit),
        .cap_o    (cap_o),
        .irq_o    (irq_o)
    );

    // R10: reset leaves the interrupt low
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> !irq_o);

endmodule

// File: tb/sim_evt_counter_top.sv
module sim_evt_counter_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         evt_i = 1'b0;
    logic         inv_i = 1'b0;
    logic [W-1:0] match_i = '0;
    logic         cap_en_i = 1'b1;
    logic [W-1:0] cap_o;
    logic         irq_o;

    always #5 clk = ~clk;

    evt_counter_top #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .evt_i(evt_i), .inv_i(inv_i),
        .match_i(match_i), .cap_en_i(cap_en_i), .cap_o(cap_o), .irq_o(irq_o)
    );

    typedef struct {
        int    cap;
        int    irq;
        string tag;
    } item_t;

    item_t sbq[$];
    event  item_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    irq_seen = 0;
    bit    prev_irq = 1'b0;
    bit    finished = 1'b0;

    // reference model state
    int m_cnt = 0;
    int m_irq = 0;
    int m_cap = 0;
    bit m_capen = 1'b1;

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // interrupt monitor: R5 single cycle, R4/R6 capture shows matched value on the clear cycle
    always @(negedge clk) begin
        if (!rst && irq_o) begin
            irq_seen++;
            check("R5 irq width (previous cycle irq)", int'(prev_irq), 0);
            if (cap_en_i) check("R4 R6 capture on clear cycle", int'(cap_o), int'(match_i));
        end
        prev_irq = irq_o;
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(item_ev);
            while (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                check({it.tag, " capture"}, int'(cap_o), it.cap);
                check({it.tag, " irq count"}, irq_seen, it.irq);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_level(bit active);
        evt_i = inv_i ? ~active : active;
    endtask

    task automatic push(string tag);
        item_t it;
        tick(6);
        if (m_capen) m_cap = m_cnt;
        it.cap = m_cap;
        it.irq = m_irq;
        it.tag = tag;
        sbq.push_back(it);
        -> item_ev;
        tick(1);
    endtask

    task automatic go_active();
        drive_level(1'b1);
        m_cnt = (m_cnt + 1) % 256;
    endtask

    task automatic go_idle();
        drive_level(1'b0);
        if (m_cnt == int'(match_i)) begin
            m_cnt = 0;
            m_irq++;
        end
    endtask

    task automatic pulse(int hi, int lo);
        go_active();
        tick(hi);
        go_idle();
        tick(lo);
    endtask

    task automatic do_reset();
        drive_level(1'b0);
        tick(2);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        m_cnt = 0;
        m_cap = 0;
        tick(2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        match_i = 8'd5;
        do_reset();
        check("R10 irq after reset", int'(irq_o), 0);
        push("R10 reset state");

        // R1 rising-edge counting
        for (int i = 0; i < 3; i++) pulse(3, 3);
        push("R1 three rising edges");

        // R7 minimum 2/2 pulses reach the match: R4 clear
        for (int i = 0; i < 2; i++) pulse(2, 2);
        push("R4 R7 match clears");

        // R3 deferred compare with a held level
        match_i = 8'd3;
        for (int i = 0; i < 2; i++) pulse(2, 2);
        push("R3 before hold");
        go_active();
        tick(10);
        push("R3 held level no irq");
        go_idle();
        push("R3 released level fires");

        // R9 match change between pulses
        match_i = 8'd9;
        for (int i = 0; i < 3; i++) pulse(3, 3);
        match_i = 8'd4;
        push("R9 before change");
        pulse(3, 3);
        push("R9 new match applied");

        // R6 capture hold and resume
        match_i = 8'd200;
        for (int i = 0; i < 2; i++) pulse(2, 3);
        push("R6 capture follows");
        cap_en_i = 1'b0;
        m_capen = 1'b0;
        for (int i = 0; i < 3; i++) pulse(2, 3);
        push("R6 capture holds");
        cap_en_i = 1'b1;
        m_capen = 1'b1;
        push("R6 capture resumes");

        // R10 reset mid-count
        do_reset();
        push("R10 mid-run reset");
        pulse(2, 2);
        push("R10 counting after reset");

        // R2 falling-edge counting
        inv_i = 1'b1;
        match_i = 8'd4;
        do_reset();
        for (int i = 0; i < 2; i++) pulse(2, 2);
        push("R2 two falling edges");
        for (int i = 0; i < 2; i++) pulse(2, 2);
        push("R2 match on rising compare");
        match_i = 8'd1;
        go_active();
        tick(10);
        push("R3 inverted held level");
        go_idle();
        push("R3 inverted release");

        // R8 wrap with match 0
        inv_i = 1'b0;
        match_i = 8'd0;
        do_reset();
        for (int i = 0; i < 255; i++) pulse(2, 2);
        push("R8 count at 255");
        pulse(2, 2);
        push("R8 wrap match fires");

        tick(4);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule